// File: doc/BRIEF.md
# I/O port address router

This block sits between the CPU's I/O request port and three targets: the on-chip register block, the internal EEPROM controller and the external cartridge bus. It decodes each 16-bit port address with a fixed priority. It steers the access to one target, or to none, in which case reads return an open-bus byte. It breaks an access into the cycles the target can take. The on-chip and EEPROM targets are 16 bits wide and take one cycle per cycle issued. The cartridge is 8 bits wide and takes one or two cycles per byte.

Each CPU request is sampled on the clock edge where `cpu_valid` is high. A new request may be raised only while no request is in flight; the cycle in which `cpu_done` is high already counts as free. The request runs as one or more beats on the shared target bus, and every beat raises exactly one select, or none for open bus. `cpu_done` pulses once, in the cycle after the last beat, with the read word in `cpu_rdata`. Byte lane 0 (`cpu_wdata[7:0]`, `cpu_rdata[7:0]`, `cpu_be[0]`) is the byte at `cpu_addr`. Lane 1 (bits 15:8, `cpu_be[1]`) is the byte at `cpu_addr`+1 (modulo 2^16). `color_mode` and `cart_fast` must stay steady while a request is in flight.

Top module: `io_port_router`

## Requirements
- R1: An address from 0x00B8 to 0x00BF, compared over all 16 bits, selects the EEPROM target (`rom_sel`). This check wins over every other check, and each EEPROM beat lasts one cycle.
- R2: Failing R1, an address from 0x00C0 to 0x00FF selects the cartridge target (`cart_sel`). The cartridge is byte-wide: each beat carries its byte on `tgt_wdata[7:0]` and returns it on `cart_rdata`.
- R3: Failing R1 and R2, an address whose bits 8:0 are at most 0x0B7 selects the on-chip register target (`reg_sel`), whatever bits 15:9 hold. At most one select is high in any cycle.
- R4: An address matched by none of R1 to R3 raises no select for one cycle. A read byte from it is 0x90 when `color_mode` is 0 and the parameter OPEN_BUS_COLOR when `color_mode` is 1. A write to it is dropped.
- R5: A word request (`cpu_be`=11) at an even address that decodes to the register or EEPROM target runs as one beat: `tgt_be`=11, `tgt_addr`=`cpu_addr`, `tgt_wdata`=`cpu_wdata`. `cpu_done` is high in the 2nd cycle after the request is taken.
- R6: Any other word request runs as two byte beats, the byte at `cpu_addr` first and then the byte at `cpu_addr`+1. Each byte is decoded on its own, and a two-beat request costs one more cycle than one beat.
- R7: A cartridge beat holds `cart_sel` and the bus for 2 cycles (CART_SLOW_CYC). It holds them for 1 cycle only when `cart_fast`=1 and `color_mode`=1.
- R8: A word request to the cartridge range always runs as two byte beats, and `cart_sel` is never high with `tgt_be`=11.
- R9: With OLD_VARIANT=1, a word request at an odd address that decodes to the EEPROM target is not split. It runs as one beat with `tgt_be`=11 at `cpu_addr`, and `cpu_rdata` takes the whole `rom_rdata`. With OLD_VARIANT=0 the same request follows R6.
- R10: Each request raises `cpu_done` for exactly one cycle, N+1 cycles after the sampling edge, where N is the total number of beat cycles. `cpu_rdata` holds the assembled read word from that cycle on, and holds 0 for writes. All selects are low in the `cpu_done` cycle.
- R11: A byte beat drives `tgt_addr` to the byte's address and `tgt_be` to 01 for an even address or 10 for an odd one. It drives the byte on both lanes of `tgt_wdata`, and a read takes the lane picked by that address bit. A single-lane request runs one beat. A request with `cpu_be`=00 accesses no target and finishes like an open-bus beat, with read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| color_mode | input | 1 | Color operation (picks the open-bus byte, allows the fast cartridge setting) |
| cart_fast | input | 1 | Cartridge one-cycle wait setting |
| cpu_valid | input | 1 | Request strobe, sampled while idle |
| cpu_addr | input | 16 | Port byte address |
| cpu_be | input | 2 | Lane enables (bit 0 = byte at addr, bit 1 = byte at addr+1) |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 16 | Write data, lane layout as cpu_be |
| cpu_rdata | output | 16 | Assembled read data |
| cpu_done | output | 1 | One-cycle completion pulse |
| tgt_addr | output | 16 | Beat address, shared by targets |
| tgt_be | output | 2 | Beat lane enables |
| tgt_we | output | 1 | Beat write flag |
| tgt_wdata | output | 16 | Beat write data |
| reg_sel | output | 1 | On-chip register target select |
| reg_rdata | input | 16 | On-chip register read data |
| rom_sel | output | 1 | EEPROM controller select |
| rom_rdata | input | 16 | EEPROM controller read data |
| cart_sel | output | 1 | Cartridge bus select |
| cart_rdata | input | 8 | Cartridge read byte |

## Verification
The bench builds two copies of the router. Both set OPEN_BUS_COLOR to 0xE7, so the mono and color open-bus bytes can be told apart. The first copy keeps OLD_VARIANT=0 and the second sets OLD_VARIANT=1. Each request goes to one copy only, so the EEPROM word access at odd addresses 0x00B9 to 0x00BD can be seen both split and unsplit. Requests that cross a range edge, such as 0x00B7, 0x00BF and 0xFFFF, show the two bytes of a split going to different targets. Addresses with high bits set show the register match ignoring them.

// File: rtl/io_router_pkg.sv
package io_router_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_ROM  = 2'd2,
    TGT_CART = 2'd3
  } tgt_e;

  // Pick one byte of a 16-bit word: hi=1 takes bits 15:8.
  function automatic logic [7:0] lane_byte(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  // Lane enable of a byte beat, taken from its address bit 0.
  function automatic logic [1:0] byte_be(input logic a0);
    return a0 ? 2'b10 : 2'b01;
  endfunction

  // A word request that can go out as a single 16-bit beat.
  function automatic logic single_word(input logic a0, input logic [1:0] be,
                                       input tgt_e t, input logic old_variant);
    logic wide_tgt;
    wide_tgt = (t == TGT_REG) || (t == TGT_ROM);
    return (be == 2'b11) &&
           ((!a0 && wide_tgt) || (a0 && old_variant && (t == TGT_ROM)));
  endfunction

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_router_pkg::*;
#(
  parameter int                  ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]   ROM_LO   = 16'h00B8,
  parameter logic [ADDR_W-1:0]   ROM_HI   = 16'h00BF,
  parameter logic [ADDR_W-1:0]   CART_LO  = 16'h00C0,
  parameter logic [ADDR_W-1:0]   CART_HI  = 16'h00FF,
  parameter int                  REG_BITS = 9,
  parameter logic [REG_BITS-1:0] REG_HI   = 9'h0B7
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);

  logic hit_rom;
  logic hit_cart;
  logic hit_reg;

  assign hit_rom  = (addr >= ROM_LO) && (addr <= ROM_HI);
  assign hit_cart = (addr >= CART_LO) && (addr <= CART_HI);
  assign hit_reg  = (addr[REG_BITS-1:0] <= REG_HI);

  always_comb begin
    if (hit_rom)       tgt = TGT_ROM;
    else if (hit_cart) tgt = TGT_CART;
    else if (hit_reg)  tgt = TGT_REG;
    else               tgt = TGT_NONE;
  end

endmodule

// File: rtl/io_beat_seq.sv
module io_beat_seq
  import io_router_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter bit OLD_VARIANT   = 1'b0,
  parameter int CART_SLOW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              color_mode,
  input  logic              cart_fast,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_be,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_wdata,
  input  tgt_e              req_tgt,
  input  tgt_e              beat_tgt,
  output logic              accept,
  output logic              beat_en,
  output logic              beat_word,
  output logic              beat_lane,
  output logic              beat_end,
  output logic              last_end,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [1:0]        beat_be,
  output logic [15:0]       beat_wdata,
  output logic              beat_we
);

  localparam int CW = (CART_SLOW_CYC > 1) ? $clog2(CART_SLOW_CYC) : 1;
  localparam logic [CW-1:0] SLOW_LAST = CW'(CART_SLOW_CYC - 1);

  logic              busy;
  logic [ADDR_W-1:0] r_addr;
  logic [1:0]        r_be;
  logic              r_we;
  logic [15:0]       r_wdata;
  logic              r_word;
  logic              lane;
  logic [CW-1:0]     cnt;

  logic              more;
  logic              cart_quick;
  logic              beat_start;
  logic [CW-1:0]     beat_last;
  logic [7:0]        lane_data;

  assign accept     = cpu_valid && !busy;
  assign beat_addr  = r_word ? r_addr : (r_addr + {{(ADDR_W-1){1'b0}}, lane});
  assign beat_en    = busy && (r_word || r_be[lane]);
  assign beat_word  = r_word;
  assign beat_lane  = lane;
  assign beat_we    = r_we;
  assign lane_data  = lane_byte(r_wdata, lane);
  assign beat_be    = r_word ? 2'b11 : byte_be(beat_addr[0]);
  assign beat_wdata = r_word ? r_wdata : {lane_data, lane_data};

  assign cart_quick = color_mode && cart_fast;
  assign beat_last  = (beat_en && (beat_tgt == TGT_CART) && !cart_quick) ? SLOW_LAST : '0;
  assign beat_start = busy && (cnt == '0);
  assign beat_end   = busy && (cnt == beat_last);
  assign more       = !r_word && !lane && r_be[1];
  assign last_end   = beat_end && !more;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      r_addr  <= '0;
      r_be    <= '0;
      r_we    <= 1'b0;
      r_wdata <= '0;
      r_word  <= 1'b0;
      lane    <= 1'b0;
      cnt     <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      r_addr  <= cpu_addr;
      r_be    <= cpu_be;
      r_we    <= cpu_we;
      r_wdata <= cpu_wdata;
      r_word  <= single_word(cpu_addr[0], cpu_be, req_tgt, OLD_VARIANT);
      lane    <= (cpu_be == 2'b10);
      cnt     <= '0;
    end else if (beat_end) begin
      cnt <= '0;
      if (more) lane <= 1'b1;
      else      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: a slow cartridge beat does not end in its first cycle
  assert_slow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_start && beat_en && (beat_tgt == TGT_CART) && !cart_quick && (CART_SLOW_CYC > 1))
      |-> !beat_end);

  // R6: after the first byte of a split, the high byte beat starts next
  assert_split_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_end && more) |=> (beat_start && lane && !r_word));

endmodule

// File: rtl/io_read_merge.sv
module io_read_merge
  import io_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        beat_end,
  input  logic        last_end,
  input  logic        beat_en,
  input  logic        beat_word,
  input  logic        beat_lane,
  input  logic        beat_a0,
  input  logic        beat_we,
  input  tgt_e        beat_tgt,
  input  logic [15:0] reg_rdata,
  input  logic [15:0] rom_rdata,
  input  logic [7:0]  cart_rdata,
  input  logic [7:0]  open_byte,
  output logic [15:0] cpu_rdata,
  output logic        cpu_done
);

  logic [15:0] word_val;
  logic [7:0]  byte_val;
  logic        capture;

  assign word_val = (beat_tgt == TGT_ROM) ? rom_rdata : reg_rdata;
  assign capture  = beat_end && beat_en && !beat_we;

  always_comb begin
    unique case (beat_tgt)
      TGT_NONE: byte_val = open_byte;
      TGT_CART: byte_val = cart_rdata;
      TGT_ROM:  byte_val = lane_byte(rom_rdata, beat_a0);
      default:  byte_val = lane_byte(reg_rdata, beat_a0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      cpu_done  <= 1'b0;
    end else begin
      cpu_done <= last_end;
      if (accept)                      cpu_rdata       <= '0;
      else if (capture && beat_word)   cpu_rdata       <= word_val;
      else if (capture && beat_lane)   cpu_rdata[15:8] <= byte_val;
      else if (capture)                cpu_rdata[7:0]  <= byte_val;
    end
  end

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

endmodule

// File: rtl/io_port_router.sv
module io_port_router
  import io_router_pkg::*;
#(
  parameter int                ADDR_W         = 16,
  parameter logic [ADDR_W-1:0] ROM_LO         = 16'h00B8,
  parameter logic [ADDR_W-1:0] ROM_HI         = 16'h00BF,
  parameter logic [ADDR_W-1:0] CART_LO        = 16'h00C0,
  parameter logic [ADDR_W-1:0] CART_HI        = 16'h00FF,
  parameter int                REG_BITS       = 9,
  parameter logic [REG_BITS-1:0] REG_HI       = 9'h0B7,
  parameter logic [7:0]        OPEN_BUS_MONO  = 8'h90,
  parameter logic [7:0]        OPEN_BUS_COLOR = 8'h90,
  parameter int                CART_SLOW_CYC  = 2,
  parameter bit                OLD_VARIANT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              color_mode,
  input  logic              cart_fast,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_be,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  output logic              cpu_done,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [1:0]        tgt_be,
  output logic              tgt_we,
  output logic [15:0]       tgt_wdata,
  output logic              reg_sel,
  input  logic [15:0]       reg_rdata,
  output logic              rom_sel,
  input  logic [15:0]       rom_rdata,
  output logic              cart_sel,
  input  logic [7:0]        cart_rdata
);

  tgt_e              req_tgt;
  tgt_e              beat_tgt;
  logic              accept;
  logic              beat_en;
  logic              beat_word;
  logic              beat_lane;
  logic              beat_end;
  logic              last_end;
  logic [ADDR_W-1:0] beat_addr;
  logic [7:0]        open_byte;

  // Two decoders: one on the incoming request, one on the current beat.
  for (genvar g = 0; g < 2; g++) begin : g_dec
    logic [ADDR_W-1:0] a;
    tgt_e              t;
    assign a = (g == 0) ? cpu_addr : beat_addr;
    io_addr_decode #(
      .ADDR_W(ADDR_W), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
      .CART_LO(CART_LO), .CART_HI(CART_HI),
      .REG_BITS(REG_BITS), .REG_HI(REG_HI)
    ) u_dec (
      .addr(a),
      .tgt (t)
    );
  end

  assign req_tgt  = g_dec[0].t;
  assign beat_tgt = g_dec[1].t;

  io_beat_seq #(
    .ADDR_W(ADDR_W), .OLD_VARIANT(OLD_VARIANT), .CART_SLOW_CYC(CART_SLOW_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .color_mode(color_mode),
    .cart_fast (cart_fast),
    .cpu_valid (cpu_valid),
    .cpu_addr  (cpu_addr),
    .cpu_be    (cpu_be),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .req_tgt   (req_tgt),
    .beat_tgt  (beat_tgt),
    .accept    (accept),
    .beat_en   (beat_en),
    .beat_word (beat_word),
    .beat_lane (beat_lane),
    .beat_end  (beat_end),
    .last_end  (last_end),
    .beat_addr (beat_addr),
    .beat_be   (tgt_be),
    .beat_wdata(tgt_wdata),
    .beat_we   (tgt_we)
  );

  assign open_byte = color_mode ? OPEN_BUS_COLOR : OPEN_BUS_MONO;

  io_read_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .beat_end  (beat_end),
    .last_end  (last_end),
    .beat_en   (beat_en),
    .beat_word (beat_word),
    .beat_lane (beat_lane),
    .beat_a0   (beat_addr[0]),
    .beat_we   (tgt_we),
    .beat_tgt  (beat_tgt),
    .reg_rdata (reg_rdata),
    .rom_rdata (rom_rdata),
    .cart_rdata(cart_rdata),
    .open_byte (open_byte),
    .cpu_rdata (cpu_rdata),
    .cpu_done  (cpu_done)
  );

  assign tgt_addr = beat_addr;
  assign reg_sel  = beat_en && (beat_tgt == TGT_REG);
  assign rom_sel  = beat_en && (beat_tgt == TGT_ROM);
  assign cart_sel = beat_en && (beat_tgt == TGT_CART);

  // R3: never more than one target selected
  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_sel, rom_sel, cart_sel}));

  // R1: EEPROM select only inside its full-width range
  assert_rom_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> ((tgt_addr >= ROM_LO) && (tgt_addr <= ROM_HI)));

  // R2: cartridge select only inside its range
  assert_cart_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cart_sel |-> ((tgt_addr >= CART_LO) && (tgt_addr <= CART_HI)));

  // R3: register select only for low-bit match outside the higher-priority ranges
  assert_reg_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> ((tgt_addr[REG_BITS-1:0] <= REG_HI) &&
                 !((tgt_addr >= ROM_LO) && (tgt_addr <= CART_HI))));

  // R8: the cartridge never sees a two-lane beat
  assert_cart_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cart_sel |-> (tgt_be != 2'b11));

  // R10: all selects are idle in the completion cycle
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !(reg_sel || rom_sel || cart_sel));

endmodule

// File: tb/tb_io_port_router.sv
`timescale 1ns/1ps
module tb_io_port_router;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        color_mode = 1'b0;
  logic        cart_fast = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [1:0]  cpu_be = '0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic        use_old = 1'b0;

  int checks = 0;
  int errors = 0;

  function automatic int dec(input logic [15:0] a);
    if (a >= 16'h00B8 && a <= 16'h00BF) return 2;
    if (a >= 16'h00C0 && a <= 16'h00FF) return 3;
    if (a[8:0] <= 9'h0B7) return 1;
    return 0;
  endfunction
  function automatic logic [15:0] reg_fn(input logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] rom_fn(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h0F0F;
  endfunction
  function automatic logic [7:0] cart_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h69;
  endfunction
  function automatic logic [2:0] sel_code(input int d);
    return (d == 1) ? 3'b001 : (d == 2) ? 3'b010 : (d == 3) ? 3'b100 : 3'b000;
  endfunction

  // Two instances: index 0 default variant, index 1 older variant
  logic [15:0] o_rd[2];
  logic        o_done[2];
  logic [15:0] o_ta[2];
  logic [1:0]  o_tb[2];
  logic        o_tw[2];
  logic [15:0] o_twd[2];
  logic        o_rs[2], o_ms[2], o_cs[2];

  io_port_router #(.OPEN_BUS_COLOR(8'hE7), .OLD_VARIANT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .cart_fast(cart_fast),
    .cpu_valid(cpu_valid && !use_old), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(o_rd[0]), .cpu_done(o_done[0]),
    .tgt_addr(o_ta[0]), .tgt_be(o_tb[0]), .tgt_we(o_tw[0]), .tgt_wdata(o_twd[0]),
    .reg_sel(o_rs[0]), .reg_rdata(reg_fn(o_ta[0])), .rom_sel(o_ms[0]),
    .rom_rdata(rom_fn(o_ta[0])), .cart_sel(o_cs[0]), .cart_rdata(cart_fn(o_ta[0])));

  io_port_router #(.OPEN_BUS_COLOR(8'hE7), .OLD_VARIANT(1'b1)) dut_old (
    .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .cart_fast(cart_fast),
    .cpu_valid(cpu_valid && use_old), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(o_rd[1]), .cpu_done(o_done[1]),
    .tgt_addr(o_ta[1]), .tgt_be(o_tb[1]), .tgt_we(o_tw[1]), .tgt_wdata(o_twd[1]),
    .reg_sel(o_rs[1]), .reg_rdata(reg_fn(o_ta[1])), .rom_sel(o_ms[1]),
    .rom_rdata(rom_fn(o_ta[1])), .cart_sel(o_cs[1]), .cart_rdata(cart_fn(o_ta[1])));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input bit old, input logic [15:0] a, input logic [1:0] be,
                         input bit we, input logic [15:0] wd, input bit col,
                         input bit fst, input string tag);
    logic [2:0]  es[16];
    logic [15:0] ea[16];
    logic [1:0]  eb[16];
    logic [15:0] ew[16];
    logic [15:0] erd;
    int          n;
    int          got;
    bit          word;
    bit          bad;
    int          bad_at;
    int          d;
    n = 0; erd = '0; got = -1; bad = 0; bad_at = 0;
    d = dec(a);
    word = (be == 2'b11) && ((!a[0] && (d == 1 || d == 2)) || (old && a[0] && d == 2));
    if (word) begin
      es[0] = sel_code(d); ea[0] = a; eb[0] = 2'b11; ew[0] = wd; n = 1;
      erd = (d == 2) ? rom_fn(a) : reg_fn(a);
    end else if (be == 2'b00) begin
      es[0] = 3'b000; ea[0] = a; eb[0] = 2'b00; ew[0] = '0; n = 1;
    end else begin
      for (int ln = 0; ln < 2; ln++) begin
        if (be[ln]) begin
          logic [15:0] ba;
          logic [7:0]  b;
          logic [7:0]  bv;
          logic [15:0] t;
          int          bd;
          int          cyc;
          ba = a + 16'(ln);
          bd = dec(ba);
          b = (ln == 1) ? wd[15:8] : wd[7:0];
          cyc = (bd == 3 && !(col && fst)) ? 2 : 1;
          for (int c = 0; c < cyc; c++) begin
            es[n] = sel_code(bd); ea[n] = ba; eb[n] = ba[0] ? 2'b10 : 2'b01;
            ew[n] = {b, b}; n++;
          end
          t = (bd == 2) ? rom_fn(ba) : reg_fn(ba);
          if (bd == 0)      bv = col ? 8'hE7 : 8'h90;
          else if (bd == 3) bv = cart_fn(ba);
          else              bv = ba[0] ? t[15:8] : t[7:0];
          if (ln == 1) erd[15:8] = bv; else erd[7:0] = bv;
        end
      end
    end
    if (we) erd = '0;

    @(negedge clk);
    use_old = old; color_mode = col; cart_fast = fst;
    cpu_addr = a; cpu_be = be; cpu_we = we; cpu_wdata = wd; cpu_valid = 1'b1;
    @(negedge clk);
    cpu_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (o_done[old]) begin got = k; break; end
      if (k < 16) begin
        logic [2:0] os;
        os = {o_cs[old], o_ms[old], o_rs[old]};
        if (k >= n || os != es[k]) begin
          if (!bad) bad_at = k;
          bad = 1;
        end else if (os != 3'b000 &&
                     (o_ta[old] != ea[k] || o_tb[old] != eb[k] ||
                      o_tw[old] != we || o_twd[old] != ew[k])) begin
          if (!bad) bad_at = k;
          bad = 1;
        end
      end
      @(negedge clk);
    end
    check(got == n, "R10", {tag, " done latency"}, 32'(got), 32'(n));
    check(!bad, tag, "beat trace at cycle", 32'(bad_at),
          {13'd0, es[bad_at < 16 ? bad_at : 0], ea[bad_at < 16 ? bad_at : 0]});
    if (got >= 0) begin
      check(o_rd[old] == erd, tag, "read data", 32'(o_rd[old]), 32'(erd));
      check({o_cs[old], o_ms[old], o_rs[old]} == 3'b000, "R10", "selects in done cycle",
            32'({o_cs[old], o_ms[old], o_rs[old]}), 32'd0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20417);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(o_done[0] == 1'b0 && o_rd[0] == 16'h0, "R10", "reset outputs",
          {15'd0, o_done[0], o_rd[0]}, 32'd0);
    check({o_cs[0], o_ms[0], o_rs[0]} == 3'b000, "R3", "reset selects",
          32'({o_cs[0], o_ms[0], o_rs[0]}), 32'd0);

    // Directed corner cases
    run_req(0, 16'h00B8, 2'b11, 0, 16'h0, 0, 0, "R1");      // EEPROM word
    run_req(0, 16'h02BA, 2'b11, 0, 16'h0, 0, 0, "R1");      // high bits: not EEPROM
    run_req(0, 16'hFE10, 2'b01, 0, 16'h0, 0, 0, "R3");      // high bits ignored
    run_req(0, 16'h7EB6, 2'b11, 0, 16'h0, 0, 0, "R3");      // last register word
    run_req(0, 16'h0100, 2'b01, 0, 16'h0, 0, 0, "R4");      // open bus mono
    run_req(0, 16'h0100, 2'b11, 0, 16'h0, 1, 0, "R4");      // open bus color
    run_req(0, 16'h0180, 2'b11, 1, 16'hBEEF, 0, 0, "R4");   // open bus write dropped
    run_req(0, 16'h0040, 2'b11, 1, 16'h1234, 0, 0, "R5");   // aligned register write
    run_req(0, 16'h00C4, 2'b11, 0, 16'h0, 0, 0, "R8");      // cartridge word slow
    run_req(0, 16'h00C4, 2'b11, 1, 16'hA55A, 1, 1, "R8");   // cartridge word fast write
    run_req(0, 16'h00D1, 2'b01, 0, 16'h0, 0, 1, "R7");      // fast ignored in mono
    run_req(0, 16'h00D1, 2'b01, 0, 16'h0, 1, 1, "R7");      // fast in color
    run_req(0, 16'h00F0, 2'b01, 1, 16'h00C3, 0, 0, "R2");   // cartridge byte write
    run_req(0, 16'h00B7, 2'b11, 0, 16'h0, 0, 0, "R6");      // register then EEPROM
    run_req(0, 16'h00BF, 2'b11, 0, 16'h0, 0, 0, "R6");      // EEPROM then cartridge
    run_req(0, 16'hFFFF, 2'b11, 0, 16'h0, 1, 0, "R6");      // open then register (wrap)
    run_req(0, 16'h0010, 2'b10, 0, 16'h0, 0, 0, "R11");     // lane 1 only
    run_req(0, 16'h0011, 2'b01, 1, 16'h0077, 0, 0, "R11");  // odd byte write
    run_req(0, 16'h0020, 2'b00, 0, 16'h0, 0, 0, "R11");     // no lanes
    run_req(0, 16'h00B9, 2'b11, 0, 16'h0, 0, 0, "R9");      // split on default variant
    run_req(1, 16'h00B9, 2'b11, 0, 16'h0, 0, 0, "R9");      // unsplit on older variant
    run_req(1, 16'h00BD, 2'b11, 1, 16'h4321, 0, 0, "R9");
    run_req(1, 16'h00BF, 2'b11, 0, 16'h0, 0, 0, "R9");      // odd EEPROM end: still one beat

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [1:0]  be;
      int          sel;
      string       tag;
      sel = int'($urandom % 4);
      case (sel)
        0: a = 16'($urandom);
        1: a = 16'h00A0 + 16'($urandom % 96);
        2: a = {7'($urandom), 9'h0A0 + 9'($urandom % 112)};
        default: a = 16'hFFF0 + 16'($urandom % 16);
      endcase
      be = 2'($urandom);
      if (be == 2'b11) tag = a[0] ? "R6" : "R5";
      else tag = "R11";
      run_req(bit'($urandom % 2), a, be, bit'($urandom % 2), 16'($urandom),
              bit'($urandom % 2), bit'($urandom % 2), tag);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule